// File: doc/BRIEF.md
# Interrupt Controller with Read-to-Acknowledge

This block gathers a parameterized number of level-sensitive interrupt lines and presents one interrupt request to a single processor. Each line can be raised by its hardware input or by a software-pending bit. It is gated by a mask bit and by a small routing register that must select processor 0. The request output is high whenever any line passes all three conditions.

Software reaches the block over a plain 32-bit register port with an address, a write strobe, a read strobe, write data and read data. The pending bits and the mask bits are each reached through two banks, one that sets bits and one that clears them. A one bit in the written word acts, and a zero bit leaves the line alone. Reading the acknowledge register picks the lowest-numbered requesting line and returns its number with a hardware-interrupt type code. The same read masks that line, so it stays quiet until software unmasks it. A deferred interrupt can be replayed by setting its pending bit and then clearing its mask.

Top module: `irq_ack_ctrl`

## Requirements
- R1: A read of offset 0x0004 returns the number of lines (parameter NUM_LINES) in bits 15:0 and zero above. Writes to it have no effect.
- R2: After reset every mask bit is 1, every pending bit is 0, every routing register is 0 and irq_out is 0.
- R3: A line requests when (hw_irq[n] or its pending bit is 1), its mask bit is 0 and its routing register holds 1. irq_out is the OR of all requesting lines and follows hw_irq without a register stage. A register write changes irq_out from the next clock cycle on.
- R4: The routing register of line n sits at 0x3000 + 4*n and holds TGT_W bits that read back as written. Any value other than 1 keeps the line from requesting.
- R5: Writing the pending-set bank (0x4000 + 4*w) sets, and writing the pending-clear bank (0x4080 + 4*w) clears, the pending bit of line 32*w + b for every 1 in data bit b. Zero bits change nothing, and a read of either bank returns the current pending word.
- R6: The mask-set bank (0x4100 + 4*w) and the mask-clear bank (0x4180 + 4*w) act on the mask bits with the same layout and the same one-bits-only rule. A read of either bank returns the current mask word.
- R7: A read of the acknowledge register at 0x2004 while a line requests returns 0x0001 in bits 31:16 and the lowest requesting line number in bits 15:0.
- R8: Such a read sets the mask bit of the returned line at the same clock edge and leaves its pending bit unchanged.
- R9: A read of the acknowledge register while no line requests returns 0 and changes no state.
- R10: Reads of unmapped offsets return 0 and writes to them are ignored. This covers misaligned offsets, routing entries at or beyond NUM_LINES, and bank words at or beyond NUM_LINES/32.
- R11: bus_rdata is registered. It carries the value for a read strobe from the clock cycle after that strobe and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hw_irq | input | NUM_LINES | Level-sensitive hardware interrupt lines |
| bus_addr | input | 16 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per access |
| bus_re | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Interrupt request to processor 0 |

## Verification
irq_out is combinational in the stored state and in hw_irq. The bench therefore checks it on the falling edge that follows a write or a change of an input, which is one clock after a register write and the same cycle for an input change. Read data is due one clock after the read strobe. The driver queues the expected word when it raises the strobe, and the monitor pops and compares it on the falling edge after the capturing rising edge. The mask side effect of an acknowledge is visible from that same cycle, so the mask read that follows an acknowledge sees it.

// File: rtl/irq_ack_pkg.sv
// Shared constants and types for the read-to-acknowledge interrupt controller.
// Assumes a 16-bit byte address space and 32-bit word accesses.
package irq_ack_pkg;
    localparam int ADDR_W = 16;

    localparam logic [ADDR_W-1:0] OFS_LINE_COUNT = 16'h0004;
    localparam logic [ADDR_W-1:0] OFS_ACK        = 16'h2004;
    localparam logic [ADDR_W-1:0] OFS_ROUTE_BASE = 16'h3000;
    // Address bits 15:9 that select the page of the four set/clear banks.
    localparam logic [6:0]        BANK_PAGE      = 7'h20;

    localparam logic [15:0] ACK_TYPE_HW = 16'd1;

    // Address bits 8:7 pick one of the four banks inside the page.
    typedef enum logic [1:0] {
        BANK_PEND_SET = 2'd0,
        BANK_PEND_CLR = 2'd1,
        BANK_MASK_SET = 2'd2,
        BANK_MASK_CLR = 2'd3
    } bank_kind_e;
endpackage

// File: rtl/irq_line_bank.sv
// Per-line pending and mask state, one generate slice per 32-line word.
// Assumes at most one bank write per cycle. An acknowledge sets the mask
// after any write to the same word has been applied.
module irq_line_bank
    import irq_ack_pkg::*;
#(
    parameter int NUM_LINES = 64,
    localparam int WORDS  = NUM_LINES / 32,
    localparam int LINE_W = $clog2(NUM_LINES),
    localparam int WORD_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  bank_kind_e           wr_kind,
    input  logic [WORD_W-1:0]    wr_word,
    input  logic [31:0]          wr_data,
    input  logic                 ack_en,
    input  logic [LINE_W-1:0]    ack_line,
    output logic [NUM_LINES-1:0] pend_q,
    output logic [NUM_LINES-1:0] mask_q
);
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic        sel;
        logic [31:0] pend_d;
        logic [31:0] mask_d;

        assign sel = wr_en && (int'(wr_word) == w);

        // Next pending and mask words for this slice.
        always_comb begin
            pend_d = pend_q[w*32 +: 32];
            mask_d = mask_q[w*32 +: 32];
            if (sel) begin
                case (wr_kind)
                    BANK_PEND_SET: pend_d = pend_d | wr_data;
                    BANK_PEND_CLR: pend_d = pend_d & ~wr_data;
                    BANK_MASK_SET: mask_d = mask_d | wr_data;
                    BANK_MASK_CLR: mask_d = mask_d & ~wr_data;
                    default: ;
                endcase
            end
            if (ack_en && ((int'(ack_line) >> 5) == w)) begin
                mask_d[ack_line[4:0]] = 1'b1;
            end
        end

        // State registers: all masked and nothing pending out of reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q[w*32 +: 32] <= '0;
                mask_q[w*32 +: 32] <= '1;
            end else begin
                pend_q[w*32 +: 32] <= pend_d;
                mask_q[w*32 +: 32] <= mask_d;
            end
        end
    end
endmodule

// File: rtl/irq_route_table.sv
// Per-line routing registers. A line counts as routed to processor 0 only
// when its register holds exactly 1. Assumes an in-range line index.
module irq_route_table #(
    parameter int NUM_LINES = 64,
    parameter int TGT_W     = 8,
    localparam int LINE_W   = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [LINE_W-1:0]    line,
    input  logic [TGT_W-1:0]     wr_data,
    output logic [TGT_W-1:0]     rd_data,
    output logic [NUM_LINES-1:0] routed
);
    logic [TGT_W-1:0] tgt_q [NUM_LINES];

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        // One routing register per line, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tgt_q[n] <= '0;
            end else if (wr_en && (int'(line) == n)) begin
                tgt_q[n] <= wr_data;
            end
        end

        assign routed[n] = (tgt_q[n] == TGT_W'(1));
    end

    assign rd_data = tgt_q[line];
endmodule

// File: rtl/irq_pick_lowest.sv
// Finds the lowest-numbered set bit of the request vector.
// Assumes nothing about the input. found is 0 when the vector is empty.
module irq_pick_lowest #(
    parameter int NUM_LINES = 64,
    localparam int LINE_W   = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0] req,
    output logic                 found,
    output logic [LINE_W-1:0]    line
);
    // Scan from the top so that the lowest set bit is written last.
    always_comb begin
        found = 1'b0;
        line  = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                line  = LINE_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_ack_ctrl.sv
// Top of the read-to-acknowledge interrupt controller. It decodes the
// register port, combines line state into one request to processor 0 and
// masks the acknowledged line on an acknowledge read.
// Assumes NUM_LINES is a multiple of 32 and at most 1024, and single-cycle
// accesses.
module irq_ack_ctrl
    import irq_ack_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int TGT_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] hw_irq,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic                 bus_re,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic                 irq_out
);
    localparam int WORDS  = NUM_LINES / 32;
    localparam int LINE_W = $clog2(NUM_LINES);
    localparam int WORD_W = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic                 aligned;
    logic                 hit_count;
    logic                 hit_ack;
    logic                 hit_route;
    logic                 hit_bank;
    logic [ADDR_W-1:0]    route_off;
    logic [LINE_W-1:0]    route_line;
    bank_kind_e           bank_kind;
    logic [WORD_W-1:0]    bank_word;
    logic [NUM_LINES-1:0] pend_q;
    logic [NUM_LINES-1:0] mask_q;
    logic [NUM_LINES-1:0] routed;
    logic [NUM_LINES-1:0] active;
    logic [TGT_W-1:0]     route_rd;
    logic                 pick_found;
    logic [LINE_W-1:0]    pick_line;
    logic                 ack_en;
    logic [31:0]          rd_next;

    // Address decode.
    assign aligned    = (bus_addr[1:0] == 2'b00);
    assign hit_count  = (bus_addr == OFS_LINE_COUNT);
    assign hit_ack    = (bus_addr == OFS_ACK);
    assign route_off  = bus_addr - OFS_ROUTE_BASE;
    assign hit_route  = (bus_addr >= OFS_ROUTE_BASE) && aligned &&
                        (route_off < ADDR_W'(4 * NUM_LINES));
    assign route_line = route_off[LINE_W+1:2];
    assign hit_bank   = (bus_addr[15:9] == BANK_PAGE) && aligned &&
                        (int'(bus_addr[6:2]) < WORDS);
    assign bank_kind  = bank_kind_e'(bus_addr[8:7]);
    assign bank_word  = WORD_W'(bus_addr[6:2]);

    // Combine line state into the request vector and the output.
    assign active  = (hw_irq | pend_q) & ~mask_q & routed;
    assign irq_out = |active;
    assign ack_en  = bus_re && hit_ack && pick_found;

    irq_line_bank #(.NUM_LINES(NUM_LINES)) bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_we && hit_bank),
        .wr_kind  (bank_kind),
        .wr_word  (bank_word),
        .wr_data  (bus_wdata),
        .ack_en   (ack_en),
        .ack_line (pick_line),
        .pend_q   (pend_q),
        .mask_q   (mask_q)
    );

    irq_route_table #(.NUM_LINES(NUM_LINES), .TGT_W(TGT_W)) route_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_we && hit_route),
        .line    (route_line),
        .wr_data (bus_wdata[TGT_W-1:0]),
        .rd_data (route_rd),
        .routed  (routed)
    );

    irq_pick_lowest #(.NUM_LINES(NUM_LINES)) pick_i (
        .req   (active),
        .found (pick_found),
        .line  (pick_line)
    );

    // Read data selection for the addressed register.
    always_comb begin
        rd_next = '0;
        if (hit_count) begin
            rd_next = 32'(NUM_LINES);
        end else if (hit_ack) begin
            if (pick_found) rd_next = {ACK_TYPE_HW, 16'(pick_line)};
        end else if (hit_route) begin
            rd_next = 32'(route_rd);
        end else if (hit_bank) begin
            case (bank_kind)
                BANK_PEND_SET, BANK_PEND_CLR: rd_next = pend_q[bank_word*32 +: 32];
                default:                      rd_next = mask_q[bank_word*32 +: 32];
            endcase
        end
    end

    // Read data register: loads on a read strobe, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_re) begin
            bus_rdata <= rd_next;
        end
    end
endmodule

// File: rtl/irq_ack_ctrl_chk.sv
// Property checker for irq_ack_ctrl, attached by bind below. It watches the
// port and the mask state that the line bank drives.
module irq_ack_ctrl_chk
    import irq_ack_pkg::*;
#(
    parameter int NUM_LINES = 64,
    localparam int LINE_W   = $clog2(NUM_LINES)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_re,
    input logic                 bus_we,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [31:0]          bus_rdata,
    input logic                 irq_out,
    input logic [NUM_LINES-1:0] mask_q
);
    logic ack_rd;
    assign ack_rd = bus_re && !bus_we && (bus_addr == OFS_ACK);

    // R2: the first cycle out of reset sees every line masked.
    assert_reset_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (&mask_q));

    // R7: an acknowledge read while a request is up yields the hardware type and a valid line.
    assert_ack_type_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && irq_out) |=> (bus_rdata[31:16] == ACK_TYPE_HW) &&
                                (int'(bus_rdata[15:0]) < NUM_LINES));

    // R8: the returned line is masked once the acknowledge completes.
    assert_ack_masks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ack_rd) && (bus_rdata[31:16] == ACK_TYPE_HW)) |->
            mask_q[bus_rdata[LINE_W-1:0]]);

    // R9: an acknowledge read with nothing requesting returns zero and keeps the masks.
    assert_idle_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && !irq_out) |=> (bus_rdata == 32'd0) && $stable(mask_q));
endmodule

bind irq_ack_ctrl irq_ack_ctrl_chk #(.NUM_LINES(NUM_LINES)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_re    (bus_re),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .mask_q    (mask_q)
);

// File: tb/irq_ack_ctrl_tb_top.sv
// Scoreboard bench: the read task queues expected words and a monitor
// compares them one clock after each read strobe.
module irq_ack_ctrl_tb_top;
    import irq_ack_pkg::*;

    localparam int N = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      hw_irq = '0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic              bus_re = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              irq_out;

    int          checks = 0;
    int          errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] mon_exp;
    string       mon_tag;

    always #5 clk = ~clk;

    irq_ack_ctrl #(.NUM_LINES(N), .TGT_W(8)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_irq    (hw_irq),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    task automatic do_write(input logic [15:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic do_read(input logic [15:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic set_hw(input int line, input logic v);
        hw_irq[line] = v;
        @(negedge clk);
    endtask

    task automatic chk_irq(input logic e, input string tag);
        checks++;
        if (irq_out !== e) begin
            errors++;
            $display("FAIL %s: irq_out actual %b expected %b", tag, irq_out, e);
        end
    endtask

    // Monitor: pops the expected word for every read strobe and compares.
    initial begin
        forever begin
            @(posedge clk);
            if (rst_n && bus_re) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R11: read data %h actual with no expected entry", bus_rdata);
                end else begin
                    mon_exp = exp_q.pop_front();
                    mon_tag = tag_q.pop_front();
                    checks++;
                    if (bus_rdata !== mon_exp) begin
                        errors++;
                        $display("FAIL %s: rdata actual %h expected %h", mon_tag, bus_rdata, mon_exp);
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state.
        chk_irq(1'b0, "R2");
        do_read(16'h0004, 32'd64, "R1");
        do_read(16'h4100, 32'hFFFF_FFFF, "R2");
        do_read(16'h4104, 32'hFFFF_FFFF, "R2");
        do_read(16'h4180, 32'hFFFF_FFFF, "R6");
        do_read(16'h4000, 32'h0, "R2");
        do_read(16'h4084, 32'h0, "R2");
        do_read(16'h3014, 32'h0, "R2");
        do_read(16'h2004, 32'h0, "R9");
        do_read(16'h4100, 32'hFFFF_FFFF, "R9");

        // Line 5: masked, then routed, then unmasked.
        set_hw(5, 1'b1);
        chk_irq(1'b0, "R3");
        do_write(16'h3014, 32'd1);
        do_read(16'h3014, 32'd1, "R4");
        chk_irq(1'b0, "R3");
        do_write(16'h4180, 32'h20);
        chk_irq(1'b1, "R3");
        do_read(16'h4100, 32'hFFFF_FFDF, "R6");
        do_write(16'h4100, 32'h20);
        chk_irq(1'b0, "R6");
        do_write(16'h4180, 32'h20);
        chk_irq(1'b1, "R6");

        // Line 40 also requests; acknowledge takes the lowest first.
        do_write(16'h30A0, 32'd1);
        do_write(16'h4184, 32'h100);
        set_hw(40, 1'b1);
        do_read(16'h2004, 32'h0001_0005, "R7");
        do_read(16'h4100, 32'hFFFF_FFFF, "R8");
        chk_irq(1'b1, "R3");
        do_read(16'h2004, 32'h0001_0028, "R7");
        chk_irq(1'b0, "R8");
        do_read(16'h4104, 32'hFFFF_FFFF, "R8");
        do_read(16'h2004, 32'h0, "R9");
        hw_irq = '0;

        // Routing gate on line 7.
        set_hw(7, 1'b1);
        do_write(16'h4180, 32'h80);
        chk_irq(1'b0, "R4");
        do_write(16'h301C, 32'd1);
        chk_irq(1'b1, "R4");
        do_write(16'h301C, 32'd2);
        chk_irq(1'b0, "R4");
        do_read(16'h301C, 32'd2, "R4");
        do_write(16'h301C, 32'd1);
        do_read(16'h2004, 32'h0001_0007, "R7");
        set_hw(7, 1'b0);

        // Software pending on line 33 (word 1, bit 1).
        do_write(16'h4004, 32'h2);
        do_read(16'h4004, 32'h2, "R5");
        do_read(16'h4084, 32'h2, "R5");
        do_write(16'h3084, 32'd1);
        chk_irq(1'b0, "R5");
        do_write(16'h4184, 32'h2);
        chk_irq(1'b1, "R5");
        do_write(16'h4084, 32'h0);
        chk_irq(1'b1, "R5");
        do_write(16'h4084, 32'h2);
        chk_irq(1'b0, "R5");
        do_read(16'h4004, 32'h0, "R5");
        do_write(16'h4004, 32'h2);
        chk_irq(1'b1, "R5");
        do_read(16'h2004, 32'h0001_0021, "R7");
        do_read(16'h4104, 32'hFFFF_FFFF, "R8");
        do_read(16'h4004, 32'h2, "R8");

        // Unmapped offsets.
        do_write(16'h4188, 32'hFFFF_FFFF);
        do_read(16'h4100, 32'hFFFF_FFFF, "R10");
        do_read(16'h4104, 32'hFFFF_FFFF, "R10");
        do_write(16'h3100, 32'd1);
        do_read(16'h3100, 32'h0, "R10");
        do_write(16'h4186, 32'hFFFF_FFFF);
        do_read(16'h4104, 32'hFFFF_FFFF, "R10");
        do_read(16'h0008, 32'h0, "R10");
        do_read(16'h4108, 32'h0, "R10");
        do_read(16'h2000, 32'h0, "R10");
        do_write(16'h0004, 32'd5);
        do_read(16'h0004, 32'd64, "R1");

        // Read data holds between reads.
        repeat (2) @(negedge clk);
        checks++;
        if (bus_rdata !== 32'd64) begin
            errors++;
            $display("FAIL R11: held rdata actual %h expected %h", bus_rdata, 32'd64);
        end

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R11: %0d expected reads actual none", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule